// File: doc/BRIEF.md
# Software Stimulus Trace Packetizer

This block turns software writes into trace packets. It has a bank of stimulus ports that sit in a small register space. A write to a port that is open to the writer becomes one packet. The packet carries the port number, the access width and the written bytes. Packets wait in a packet queue until the output can take them.

Two other sources share the output with the queue. A hardware event source sends a one-byte event code. A timestamp source sends the low bytes of a global time value. A single serializer takes one whole packet at a time from the source that wins a fixed priority. It then sends that packet byte by byte on a valid/ready stream, one byte per handshake.

Software configures two masks. The open mask enables ports one by one. The guard mask marks ports that only privileged writers may use. Software can poll any stimulus port to learn whether the queue has room.

Top module: `stim_trace_top`

## Requirements
- R1: Address map. Addresses 0 to NPORTS-1 are stimulus ports. Address NPORTS holds the open mask, where bit n enables port n. Address NPORTS+1 holds the guard mask, where bit n=1 means port n accepts only privileged writes. Both masks read back in full. Both change only on a write with `bus_priv`=1. A write with `bus_priv`=0 leaves them unchanged.
- R2: An accepted stimulus write emits one packet. The first byte is a header: bits [7:3] hold the port number, bit 2 is 0, and bits [1:0] hold the size code (01 = 1 byte, 10 = 2 bytes, 11 = 4 bytes). The header is followed by that many bytes of write data, least significant byte first.
- R3: No packet is produced by a write to a port whose open bit is 0, or by a write with size code 00.
- R4: A write with `bus_priv`=0 to a port whose guard bit is 1 produces no packet. The same write with `bus_priv`=1 is accepted.
- R5: The queue holds FIFO_DEPTH packets (default 8). A stimulus write that arrives while the queue is full is dropped, and the packets already held are kept in order.
- R6: Reading any stimulus port address returns 1 in bit 0 when the queue can accept another packet, and 0 when it is full. All other bits read 0.
- R7: An event packet is header 8'h04 followed by `evt_code`. A timestamp packet is header 8'h0C followed by `global_time[47:0]`, taken in the request cycle and sent least significant byte first. A request that arrives while the same source still has a packet waiting is dropped.
- R8: When the serializer is idle and several sources are waiting, it takes the event packet first, then the oldest stimulus packet, then the timestamp packet.
- R9: The bytes of one packet are sent back to back with no bytes from another packet between them. While `out_valid`=1 and `out_ready`=0, both `out_valid` and `out_byte` hold.
- R10: After reset, `out_valid` is 0, both masks are 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (6) | Register address, used for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size code (01/10/11) |
| bus_priv | input | 1 | 1 = privileged access |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_req | input | 1 | Hardware event request pulse |
| evt_code | input | EVT_W (8) | Hardware event code |
| ts_req | input | 1 | Timestamp packet request pulse |
| global_time | input | TIME_W (64) | Global time base |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output trace byte |
| out_ready | input | 1 | Downstream ready |

## Verification
Two kinds of events can land in the same cycle.

The first is a stimulus write pushing into the queue in the same cycle that the serializer pops from it. The bench provokes this with back-to-back writes while the output is stalled. It then checks that exactly the expected number of packets survive, that the last write is dropped, and that the port status reads 0.

The second is an event request, a timestamp request and a stimulus write all issued in one cycle while the serializer is still busy. The bench judges arbitration from the order of the drained byte stream and from the timestamp value taken in the request cycle.

// File: rtl/stim_trace_pkg.sv
package stim_trace_pkg;

   localparam int HDR_PORT_W = 5;
   localparam logic [7:0] HDR_EVENT = 8'h04;
   localparam logic [7:0] HDR_TIME  = 8'h0C;

   typedef enum logic [1:0] {
      SZ_NONE = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_HALF = 2'b10,
      SZ_WORD = 2'b11
   } acc_size_e;

   typedef struct packed {
      logic [HDR_PORT_W-1:0] port;
      acc_size_e             size;
      logic [31:0]           data;
   } stim_pkt_t;

   function automatic int unsigned size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         SZ_WORD: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/stim_trace_regs.sv
module stim_trace_regs
   import stim_trace_pkg::*;
#(
   parameter int NPORTS = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic              bus_priv,
   input  logic              fifo_full,
   output logic [31:0]       bus_rdata,
   output logic              push,
   output stim_pkt_t         push_pkt
);

   localparam int IDX_W = $clog2(NPORTS);
   localparam logic [ADDR_W-1:0] ADDR_OPEN  = ADDR_W'(NPORTS);
   localparam logic [ADDR_W-1:0] ADDR_GUARD = ADDR_W'(NPORTS + 1);

   logic [NPORTS-1:0] open_mask;
   logic [NPORTS-1:0] guard_mask;
   logic              is_port;
   logic [IDX_W-1:0]  idx;
   logic              allowed;

   assign is_port = (bus_addr < ADDR_W'(NPORTS));
   assign idx     = bus_addr[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_mask  <= '0;
         guard_mask <= '0;
      end else if (bus_wr && bus_priv) begin
         if (bus_addr == ADDR_OPEN)  open_mask  <= bus_wdata[NPORTS-1:0];
         if (bus_addr == ADDR_GUARD) guard_mask <= bus_wdata[NPORTS-1:0];
      end
   end

   assign allowed = open_mask[idx] && (!guard_mask[idx] || bus_priv);
   assign push    = bus_wr && is_port && allowed
                    && (acc_size_e'(bus_size) != SZ_NONE) && !fifo_full;

   always_comb begin
      push_pkt.port = HDR_PORT_W'(idx);
      push_pkt.size = acc_size_e'(bus_size);
      push_pkt.data = bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (is_port)                    bus_rdata[0]        = !fifo_full;
      else if (bus_addr == ADDR_OPEN)  bus_rdata[NPORTS-1:0] = open_mask;
      else if (bus_addr == ADDR_GUARD) bus_rdata[NPORTS-1:0] = guard_mask;
   end

   // R1: unprivileged writes never alter configuration
   a_r1_ctrl_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_priv) |=> ($stable(open_mask) && $stable(guard_mask)));

   // R3: closed ports never push
   a_r3_closed_port: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_port && !open_mask[idx]) |-> !push);

endmodule

// File: rtl/stim_trace_fifo.sv
module stim_trace_fifo #(
   parameter int WIDTH = 39,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   // R5: the write gate upstream must never push into a full queue
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5: the serializer must never pop an empty queue
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/stim_trace_out.sv
module stim_trace_out
   import stim_trace_pkg::*;
#(
   parameter int TS_BYTES = 6,
   parameter int TIME_W   = 64,
   parameter int EVT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stim_avail,
   input  stim_pkt_t         stim_pkt,
   output logic              stim_pop,
   input  logic              evt_req,
   input  logic [EVT_W-1:0]  evt_code,
   input  logic              ts_req,
   input  logic [TIME_W-1:0] global_time,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   input  logic              out_ready
);

   localparam int TS_W      = TS_BYTES * 8;
   localparam int EVT_BYTES = (EVT_W + 7) / 8;
   localparam int LEN_STIM  = 5;
   localparam int LEN_TS    = 1 + TS_BYTES;
   localparam int LEN_EVT   = 1 + EVT_BYTES;
   localparam int MAX_A     = (LEN_TS > LEN_STIM) ? LEN_TS : LEN_STIM;
   localparam int BUF_BYTES = (LEN_EVT > MAX_A) ? LEN_EVT : MAX_A;
   localparam int BUF_W     = BUF_BYTES * 8;
   localparam int CNT_W     = $clog2(BUF_BYTES + 1);

   logic [BUF_W-1:0] sh_buf, ld_buf;
   logic [CNT_W-1:0] left, ld_len;
   logic             idle, g_evt, g_stim, g_ts, load;
   logic             evt_pend, ts_pend;
   logic [EVT_W-1:0] evt_val;
   logic [TS_W-1:0]  ts_val;

   generate
      if (TS_W < TIME_W) begin : g_time_hi
         logic unused_time_hi;
         assign unused_time_hi = ^global_time[TIME_W-1:TS_W];
      end
   endgenerate

   // fixed priority: event, stimulus queue, timestamp
   assign idle     = (left == '0);
   assign g_evt    = idle && evt_pend;
   assign g_stim   = idle && !evt_pend && stim_avail;
   assign g_ts     = idle && !evt_pend && !stim_avail && ts_pend;
   assign load     = g_evt || g_stim || g_ts;
   assign stim_pop = g_stim;

   always_comb begin
      ld_buf = '0;
      ld_len = '0;
      if (g_evt) begin
         ld_buf = BUF_W'({evt_val, HDR_EVENT});
         ld_len = CNT_W'(LEN_EVT);
      end else if (g_stim) begin
         ld_buf = BUF_W'({stim_pkt.data, stim_pkt.port, 1'b0, stim_pkt.size});
         ld_len = CNT_W'(1 + size_bytes(stim_pkt.size));
      end else if (g_ts) begin
         ld_buf = BUF_W'({ts_val, HDR_TIME});
         ld_len = CNT_W'(LEN_TS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_buf   <= '0;
         left     <= '0;
         evt_pend <= 1'b0;
         evt_val  <= '0;
         ts_pend  <= 1'b0;
         ts_val   <= '0;
      end else begin
         if (load) begin
            sh_buf <= ld_buf;
            left   <= ld_len;
         end else if (out_valid && out_ready) begin
            sh_buf <= sh_buf >> 8;
            left   <= left - 1'b1;
         end

         if (g_evt) begin
            evt_pend <= 1'b0;
         end else if (evt_req && !evt_pend) begin
            evt_pend <= 1'b1;
            evt_val  <= evt_code;
         end

         if (g_ts) begin
            ts_pend <= 1'b0;
         end else if (ts_req && !ts_pend) begin
            ts_pend <= 1'b1;
            ts_val  <= global_time[TS_W-1:0];
         end
      end
   end

   assign out_valid = !idle;
   assign out_byte  = sh_buf[7:0];

   // R9: a stalled byte holds until accepted
   a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

   // R8: a waiting event wins as soon as the serializer is idle
   a_r8_evt_first: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && evt_pend) |=> (out_valid && out_byte == HDR_EVENT));

   // R2: a loaded stimulus packet starts with a well-formed header
   a_r2_stim_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      stim_pop |=> (out_valid && !out_byte[2] && out_byte[1:0] != 2'b00));

endmodule

// File: rtl/stim_trace_top.sv
module stim_trace_top
   import stim_trace_pkg::*;
#(
   parameter int NPORTS     = 32,
   parameter int FIFO_DEPTH = 8,
   parameter int TS_BYTES   = 6,
   parameter int TIME_W     = 64,
   parameter int EVT_W      = 8,
   parameter int ADDR_W     = $clog2(NPORTS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [1:0]        bus_size,
   input  logic              bus_priv,
   output logic [31:0]       bus_rdata,
   input  logic              evt_req,
   input  logic [EVT_W-1:0]  evt_code,
   input  logic              ts_req,
   input  logic [TIME_W-1:0] global_time,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   input  logic              out_ready
);

   localparam int PKT_W = $bits(stim_pkt_t);

   generate
      if (NPORTS < 2 || NPORTS > 32 || (NPORTS & (NPORTS - 1)) != 0) begin : g_bad_nports
         $error("NPORTS must be a power of two between 2 and 32");
      end
      if (ADDR_W != $clog2(NPORTS) + 1) begin : g_bad_addr
         $error("ADDR_W must equal clog2(NPORTS)+1");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (TS_BYTES < 1 || TS_BYTES * 8 > TIME_W) begin : g_bad_ts
         $error("TS_BYTES must fit inside TIME_W");
      end
      if (EVT_W < 1) begin : g_bad_evt
         $error("EVT_W must be positive");
      end
   endgenerate

   logic             push, pop, full, empty;
   stim_pkt_t        push_pkt;
   logic [PKT_W-1:0] q_rdata;

   stim_trace_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_size  (bus_size),
      .bus_priv  (bus_priv),
      .fifo_full (full),
      .bus_rdata (bus_rdata),
      .push      (push),
      .push_pkt  (push_pkt)
   );

   stim_trace_fifo #(.WIDTH(PKT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (push_pkt),
      .pop   (pop),
      .rdata (q_rdata),
      .full  (full),
      .empty (empty)
   );

   stim_trace_out #(.TS_BYTES(TS_BYTES), .TIME_W(TIME_W), .EVT_W(EVT_W)) out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .stim_avail  (!empty),
      .stim_pkt    (stim_pkt_t'(q_rdata)),
      .stim_pop    (pop),
      .evt_req     (evt_req),
      .evt_code    (evt_code),
      .ts_req      (ts_req),
      .global_time (global_time),
      .out_valid   (out_valid),
      .out_byte    (out_byte),
      .out_ready   (out_ready)
   );

endmodule

// File: tb/stim_trace_top_tb_top.sv
module stim_trace_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [1:0]  bus_size;
   logic        bus_priv;
   logic [31:0] bus_rdata;
   logic        evt_req;
   logic [7:0]  evt_code;
   logic        ts_req;
   logic [63:0] global_time;
   logic        out_valid;
   logic [7:0]  out_byte;
   logic        out_ready;

   always #2 clk = ~clk;

   stim_trace_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_priv(bus_priv),
      .bus_rdata(bus_rdata), .evt_req(evt_req), .evt_code(evt_code),
      .ts_req(ts_req), .global_time(global_time), .out_valid(out_valid),
      .out_byte(out_byte), .out_ready(out_ready)
   );

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   logic [7:0] got[$];
   logic [7:0] exp_q[$];

   // vector: {addr, size, priv, expect_accept, data}
   localparam int NVEC = 9;
   localparam logic [41:0] VEC [NVEC] = '{
      {6'd5,  2'd3, 1'b0, 1'b1, 32'hA1B2C3D4},
      {6'd7,  2'd1, 1'b0, 1'b1, 32'h123456EE},
      {6'd9,  2'd2, 1'b0, 1'b1, 32'hCAFEBEEF},
      {6'd0,  2'd3, 1'b0, 1'b0, 32'h11111111},
      {6'd2,  2'd3, 1'b0, 1'b0, 32'h22222222},
      {6'd2,  2'd1, 1'b1, 1'b1, 32'h00000055},
      {6'd31, 2'd2, 1'b0, 1'b0, 32'h33333333},
      {6'd31, 2'd3, 1'b1, 1'b1, 32'h01020304},
      {6'd4,  2'd0, 1'b1, 1'b0, 32'h44444444}
   };

   // outputs sampled at falling edge; inputs change just after rising edge
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) got.push_back(out_byte);
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         errs++;
         checks++;
         $display("FAIL all-requirements: watchdog expired, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d, input logic p);
      bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d; bus_priv = p;
      tick();
      bus_wr = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic read_chk(input logic [5:0] a, input logic [31:0] expv, input string tag);
      bus_addr = a;
      @(negedge clk);
      chk(bus_rdata == expv, tag, 64'(bus_rdata), 64'(expv));
      tick();
   endtask

   task automatic push_stim_exp(input logic [5:0] port, input logic [1:0] sz, input logic [31:0] d);
      int n;
      n = (sz == 2'd1) ? 1 : (sz == 2'd2) ? 2 : 4;
      exp_q.push_back({port[4:0], 1'b0, sz});
      for (int k = 0; k < n; k++) exp_q.push_back(d[8*k +: 8]);
   endtask

   task automatic cmp_stream(input string tag);
      bit ok;
      int bad;
      ok = (got.size() == exp_q.size());
      bad = -1;
      if (ok) begin
         for (int k = 0; k < got.size(); k++) begin
            if (got[k] != exp_q[k] && bad < 0) begin
               bad = k;
               ok = 1'b0;
            end
         end
      end
      checks++;
      if (!ok) begin
         errs++;
         if (bad >= 0)
            $display("FAIL %s: byte %0d actual=%0h expected=%0h", tag, bad, got[bad], exp_q[bad]);
         else
            $display("FAIL %s: byte count actual=%0d expected=%0d", tag, got.size(), exp_q.size());
      end
      got.delete();
      exp_q.delete();
   endtask

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_size = '0;
      bus_priv = 1'b0; evt_req = 1'b0; evt_code = '0; ts_req = 1'b0;
      global_time = '0; out_ready = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R10 reset state
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
      tick();
      read_chk(6'd32, 32'h0, "R10 open mask after reset");
      read_chk(6'd33, 32'h0, "R10 guard mask after reset");
      read_chk(6'd3,  32'h1, "R6 status with empty queue");

      // configure: port 0 closed, ports 2 and 31 guarded
      bus_write(6'd32, 2'd3, 32'hFFFF_FFFE, 1'b1);
      bus_write(6'd33, 2'd3, 32'h8000_0004, 1'b1);
      // R1 unprivileged control write ignored
      bus_write(6'd32, 2'd3, 32'h0, 1'b0);
      read_chk(6'd32, 32'hFFFF_FFFE, "R1 open mask after unprivileged write");
      read_chk(6'd33, 32'h8000_0004, "R1 guard mask readback");

      // vector walk: R2 accepted, R3 closed/size 00, R4 guarded
      out_ready = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         logic [5:0]  va;
         logic [1:0]  vs;
         logic        vp, ve;
         logic [31:0] vd;
         string       tag;
         {va, vs, vp, ve, vd} = VEC[i];
         if (ve) push_stim_exp(va, vs, vd);
         tag = ve ? "R2 accepted write packet"
             : ((!vp && (va == 6'd2 || va == 6'd31)) ? "R4 guarded port dropped"
                                                     : "R3 closed port or size 00 dropped");
         bus_write(va, vs, vd, vp);
         repeat (10) tick();
         cmp_stream(tag);
      end

      // R5 / R6: fill queue with output stalled; push and pop collide
      out_ready = 1'b0;
      for (int i = 0; i < 10; i++) bus_write(6'd1, 2'd1, 32'(i), 1'b0);
      @(negedge clk);
      chk(out_valid && out_byte == 8'h09, "R9 stalled header present", 64'(out_byte), 64'h09);
      tick();
      repeat (3) tick();
      @(negedge clk);
      chk(out_valid && out_byte == 8'h09, "R9 stalled byte holds", 64'(out_byte), 64'h09);
      tick();
      read_chk(6'd1, 32'h0, "R6 status with full queue");
      for (int i = 0; i < 9; i++) push_stim_exp(6'd1, 2'd1, 32'(i));
      out_ready = 1'b1;
      repeat (40) tick();
      cmp_stream("R5 full queue keeps 9, drops 10th");
      read_chk(6'd1, 32'h1, "R6 status after drain");

      // R7 / R8: three sources in one cycle while serializer is busy
      out_ready = 1'b0;
      bus_write(6'd3, 2'd1, 32'hAA, 1'b0);
      repeat (3) tick();
      evt_req = 1'b1; evt_code = 8'h5C; ts_req = 1'b1;
      global_time = 64'h1122_3344_5566_7788;
      bus_write(6'd6, 2'd1, 32'hBB, 1'b0);
      evt_req = 1'b0; ts_req = 1'b0; global_time = 64'hDEAD_BEEF_0000_0000;
      repeat (2) tick();
      out_ready = 1'b1;
      repeat (30) tick();
      push_stim_exp(6'd3, 2'd1, 32'hAA);
      exp_q.push_back(8'h04); exp_q.push_back(8'h5C);
      push_stim_exp(6'd6, 2'd1, 32'hBB);
      exp_q.push_back(8'h0C);
      for (int k = 0; k < 6; k++) exp_q.push_back(8'(64'h1122_3344_5566_7788 >> (8*k)));
      begin
         bit ord_ok;
         ord_ok = (got.size() >= 6);
         if (ord_ok) ord_ok = (got[2] == 8'h04 && got[4] == 8'h31 && got[6] == 8'h0C);
         chk(ord_ok, "R8 event before stimulus before timestamp",
             64'(got.size() >= 7 ? {got[2], got[4], got[6]} : 24'h0), 64'h04310C);
      end
      cmp_stream("R7 event and timestamp packet bytes");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule